// File: doc/BRIEF.md
# Escalating Repair Decision Controller

This controller runs the periodic test pass for a small pool of redundant sub-blocks. When a test pass is requested it samples three monitor readings: die temperature, supply voltage, and the gain of the sub-block that is currently selected. If the readings are healthy, it emits one log record holding all three values and takes no action. If they are not, it works through a fixed ladder of remedies. It first commands the operating conditions back to nominal. If the gain is still bad after a settle delay, it treats the drift as long-term and steps a digital tuning code. When no tuning codes remain, it retires the active sub-block and selects a spare.

Gain is carried in 0.1 dB steps, temperature in 0.5 °C steps and supply in millivolts, all as signed integers. The acceptance window for gain is 19.0 to 21.0 dB. Operating conditions count as healthy from -25 °C to 75 °C and from 1175 mV to 1225 mV. The restore setpoints are 25 °C and 1200 mV. After every remedy the controller waits a programmable number of cycles and then rechecks the gain. It repeats this until the gain is back in the window, or until nothing is left to try, at which point it raises a sticky fatal flag. Log records leave through a valid/ready port. A stalled consumer holds the controller back, so no record is dropped.

Top module: `repair_escalator`

## Requirements
- R1: After reset, tune_code is 0, unit_sel is 4'b0001 (bit i set selects sub-block i), and restore_cmd, log_valid and fatal are all 0.
- R2: A test pass whose gain is in 190..210, temperature in -50..150 and supply in 1175..1225 produces exactly one log record carrying those three values, with no restore pulse and no change to tune_code or unit_sel.
- R3: A test pass with any reading out of range raises restore_cmd for exactly one cycle, with temp_setpt = 50 and volt_setpt = 1200. The gain is rechecked settle_cycles+1 cycles later, and log_valid rises settle_cycles+2 cycles after the restore pulse when that recheck passes.
- R4: A recheck that finds the gain inside 190..210 emits one log record with the values sampled at the recheck, and does not step the tuning code.
- R5: A recheck that finds the gain outside the window while tune_code < 7 increments tune_code by one. A further recheck follows after another settle delay.
- R6: A failing recheck with tune_code = 7 and a spare left moves unit_sel to the next sub-block (its one-hot bit one position higher) and sets tune_code to 0.
- R7: A failing recheck with tune_code = 7 on sub-block 3 sets fatal. fatal then stays 1 until reset, and later test requests cause no restore pulse, no log record and no change to tune_code or unit_sel.
- R8: While log_valid is 1 and log_ready is 0, the record holds its values and no new test pass starts. A request made during that time is remembered and starts once the record has been accepted.
- R9: Temperature or supply outside its range triggers the restore pulse even when the gain is inside its window.
- R10: All range limits are inclusive: a gain of 190, a temperature of 150 and a supply of 1175 count as healthy, while a gain of 211 or a supply of 1226 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_go | input | 1 | Request one test pass |
| settle_cycles | input | 8 | Settle delay before each recheck |
| gain_in | input | 12 | Monitored gain, signed, 0.1 dB units |
| temp_in | input | 10 | Monitored temperature, signed, 0.5 °C units |
| volt_in | input | 13 | Monitored supply, signed, mV |
| restore_cmd | output | 1 | One-cycle command to restore nominal conditions |
| temp_setpt | output | 10 | Temperature setpoint for the restore command |
| volt_setpt | output | 13 | Supply setpoint for the restore command |
| tune_code | output | 3 | Digital tuning code of the active sub-block |
| unit_sel | output | 4 | One-hot select of the active sub-block |
| log_valid | output | 1 | Log record available |
| log_ready | input | 1 | Consumer accepts the log record |
| log_gain | output | 12 | Logged gain |
| log_temp | output | 10 | Logged temperature |
| log_volt | output | 13 | Logged supply |
| fatal | output | 1 | Sticky: every remedy used up |

## Verification
The hardest state to reach is the fatal state. Getting there takes every tuning code on every sub-block, which means about thirty failing rechecks in a row. The bench reaches it by holding the gain far outside the window for one long episode, so the recheck loop walks the whole ladder by itself. An earlier partial episode is released mid-ladder, which shows that the tuning state carries over. A stalled log record with a request arriving during the stall also needs careful timing. The bench drops log_ready, issues the request while the record is held, and then checks that the pending pass starts after the record is accepted.

// File: rtl/repair_pkg.sv
// Package: shared state encoding for the repair escalation controller.
// Assumes: nothing beyond IEEE 1800-2017.
package repair_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a test request
        ST_WAIT  = 2'd1,   // settle delay after a remedy
        ST_RECHK = 2'd2,   // one-cycle gain recheck
        ST_LOG   = 2'd3    // log record outstanding
    } esc_state_t;
endpackage

// File: rtl/range_check.sv
// Module: inclusive signed range comparator.
// Assumes: LO <= HI; the value is a signed two's-complement reading.
module range_check #(
    parameter int W  = 12,
    parameter int LO = 0,
    parameter int HI = 0
) (
    input  logic signed [W-1:0] value,
    output logic                in_range
);
    // Purpose: flag a reading that lies inside [LO, HI].
    always_comb in_range = (int'(value) >= LO) && (int'(value) <= HI);
endmodule

// File: rtl/tune_ladder.sv
// Module: tuning code and spare selection ladder.
// Each step advances the tuning code; past the last code it moves to the
// next sub-block and restarts the code at zero.
// Assumes: step is never asserted while exhausted is high.
module tune_ladder #(
    parameter int CODES = 8,
    parameter int UNITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    output logic [$clog2(CODES)-1:0] tune_code,
    output logic [UNITS-1:0]         unit_sel,
    output logic                     exhausted
);
    localparam int TW = $clog2(CODES);
    localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1;
    localparam logic [TW-1:0] LAST_CODE = TW'(CODES - 1);
    localparam logic [UW-1:0] LAST_UNIT = UW'(UNITS - 1);

    logic [TW-1:0] code_q;
    logic [UW-1:0] unit_q;

    // Purpose: advance the ladder by one rung on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            unit_q <= '0;
        end else if (step) begin
            if (code_q != LAST_CODE) begin
                code_q <= code_q + 1'b1;
            end else if (unit_q != LAST_UNIT) begin
                code_q <= '0;
                unit_q <= unit_q + 1'b1;
            end
        end
    end

    // Purpose: decode the unit index into a one-hot select.
    for (genvar i = 0; i < UNITS; i++) begin : g_sel
        assign unit_sel[i] = (unit_q == UW'(i));
    end

    assign tune_code = code_q;
    assign exhausted = (code_q == LAST_CODE) && (unit_q == LAST_UNIT);

    p_code_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && code_q != LAST_CODE) |=> (code_q == $past(code_q) + 1'b1) && $stable(unit_q));
    p_spare_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && code_q == LAST_CODE && unit_q != LAST_UNIT) |=> (code_q == '0) && (unit_q == $past(unit_q) + 1'b1));
    p_hold_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(code_q) && $stable(unit_q));
endmodule

// File: rtl/log_port.sv
// Module: single-entry log record holder with a valid/ready handshake.
// Assumes: load is only asserted while the holder is empty or being drained.
module log_port #(
    parameter int GW = 12,
    parameter int TW = 10,
    parameter int VW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [GW-1:0] d_gain,
    input  logic signed [TW-1:0] d_temp,
    input  logic signed [VW-1:0] d_volt,
    input  logic                 ready,
    output logic                 valid,
    output logic signed [GW-1:0] q_gain,
    output logic signed [TW-1:0] q_temp,
    output logic signed [VW-1:0] q_volt,
    output logic                 taken
);
    // Purpose: capture a record on load and release it on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            q_gain <= '0;
            q_temp <= '0;
            q_volt <= '0;
        end else if (load) begin
            valid  <= 1'b1;
            q_gain <= d_gain;
            q_temp <= d_temp;
            q_volt <= d_volt;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    assign taken = valid && ready;

    p_record_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid && $stable(q_gain) && $stable(q_temp) && $stable(q_volt));
endmodule

// File: rtl/repair_escalator.sv
// Module: top of the escalating repair decision controller.
// On each test request it checks gain, temperature and supply. Healthy
// readings are logged; otherwise it restores conditions, then steps the
// tuning ladder after every failing recheck, and finally raises fatal.
// Assumes: monitor inputs are synchronous to clk; settle_cycles is stable
// during an episode.
module repair_escalator
    import repair_pkg::*;
#(
    parameter int GAIN_W     = 12,
    parameter int TEMP_W     = 10,
    parameter int VOLT_W     = 13,
    parameter int SETTLE_W   = 8,
    parameter int TUNE_CODES = 8,
    parameter int UNITS      = 4,
    parameter int GAIN_LO    = 190,
    parameter int GAIN_HI    = 210,
    parameter int TEMP_LO    = -50,
    parameter int TEMP_HI    = 150,
    parameter int VOLT_LO    = 1175,
    parameter int VOLT_HI    = 1225,
    parameter int TEMP_NOM   = 50,
    parameter int VOLT_NOM   = 1200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          test_go,
    input  logic [SETTLE_W-1:0]           settle_cycles,
    input  logic signed [GAIN_W-1:0]      gain_in,
    input  logic signed [TEMP_W-1:0]      temp_in,
    input  logic signed [VOLT_W-1:0]      volt_in,
    output logic                          restore_cmd,
    output logic signed [TEMP_W-1:0]      temp_setpt,
    output logic signed [VOLT_W-1:0]      volt_setpt,
    output logic [$clog2(TUNE_CODES)-1:0] tune_code,
    output logic [UNITS-1:0]              unit_sel,
    output logic                          log_valid,
    input  logic                          log_ready,
    output logic signed [GAIN_W-1:0]      log_gain,
    output logic signed [TEMP_W-1:0]      log_temp,
    output logic signed [VOLT_W-1:0]      log_volt,
    output logic                          fatal
);
    esc_state_t          state;
    logic [SETTLE_W-1:0] wait_cnt;
    logic                go_pend;
    logic                gain_ok, temp_ok, volt_ok, all_ok;
    logic                start, log_load, tune_step, exhausted, log_taken;

    range_check #(.W(GAIN_W), .LO(GAIN_LO), .HI(GAIN_HI)) u_gain_rc (.value(gain_in), .in_range(gain_ok));
    range_check #(.W(TEMP_W), .LO(TEMP_LO), .HI(TEMP_HI)) u_temp_rc (.value(temp_in), .in_range(temp_ok));
    range_check #(.W(VOLT_W), .LO(VOLT_LO), .HI(VOLT_HI)) u_volt_rc (.value(volt_in), .in_range(volt_ok));

    // Purpose: combine the decisions taken in the current cycle.
    always_comb begin
        all_ok    = gain_ok && temp_ok && volt_ok;
        start     = (state == ST_IDLE) && (test_go || go_pend) && !fatal;
        log_load  = (start && all_ok) || ((state == ST_RECHK) && gain_ok);
        tune_step = (state == ST_RECHK) && !gain_ok && !exhausted;
    end

    tune_ladder #(.CODES(TUNE_CODES), .UNITS(UNITS)) u_ladder (
        .clk(clk), .rst_n(rst_n), .step(tune_step),
        .tune_code(tune_code), .unit_sel(unit_sel), .exhausted(exhausted)
    );

    log_port #(.GW(GAIN_W), .TW(TEMP_W), .VW(VOLT_W)) u_log (
        .clk(clk), .rst_n(rst_n), .load(log_load),
        .d_gain(gain_in), .d_temp(temp_in), .d_volt(volt_in),
        .ready(log_ready), .valid(log_valid),
        .q_gain(log_gain), .q_temp(log_temp), .q_volt(log_volt),
        .taken(log_taken)
    );

    // Purpose: sequence test passes, remedies, rechecks and the fatal stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            wait_cnt    <= '0;
            go_pend     <= 1'b0;
            restore_cmd <= 1'b0;
            fatal       <= 1'b0;
        end else begin
            restore_cmd <= 1'b0;
            go_pend     <= !fatal && !start && (go_pend || test_go);
            case (state)
                ST_IDLE: if (start) begin
                    if (all_ok) begin
                        state <= ST_LOG;
                    end else begin
                        restore_cmd <= 1'b1;
                        wait_cnt    <= settle_cycles;
                        state       <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt == '0) state <= ST_RECHK;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                ST_RECHK: begin
                    if (gain_ok) begin
                        state <= ST_LOG;
                    end else if (exhausted) begin
                        fatal <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        wait_cnt <= settle_cycles;
                        state    <= ST_WAIT;
                    end
                end
                ST_LOG: if (log_taken) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign temp_setpt = TEMP_W'(TEMP_NOM);
    assign volt_setpt = VOLT_W'(VOLT_NOM);

    p_restore_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restore_cmd |=> !restore_cmd);
    p_fatal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
    p_fatal_exhausted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal) |-> exhausted);
    p_unit_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(unit_sel));
    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !log_ready) |=> !restore_cmd);
endmodule

// File: tb/sim_repair_escalator.sv
// Bench: behavioural reference compared every clock, plus directed scenarios.
module sim_repair_escalator;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               test_go = 1'b0;
    logic [7:0]         settle = 8'd2;
    logic signed [11:0] gain = 12'sd200;
    logic signed [9:0]  temp = 10'sd50;
    logic signed [12:0] volt = 13'sd1200;
    logic               log_ready = 1'b1;
    logic               restore_cmd, log_valid, fatal;
    logic signed [9:0]  temp_setpt, log_temp;
    logic signed [12:0] volt_setpt, log_volt;
    logic signed [11:0] log_gain;
    logic [2:0]         tune_code;
    logic [3:0]         unit_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_on   = 1'b0;
    int rec_cnt  = 0;
    int rst_cnt  = 0;

    always #10 clk = ~clk;  // 50 MHz

    repair_escalator u0 (
        .clk(clk), .rst_n(rst_n), .test_go(test_go), .settle_cycles(settle),
        .gain_in(gain), .temp_in(temp), .volt_in(volt),
        .restore_cmd(restore_cmd), .temp_setpt(temp_setpt), .volt_setpt(volt_setpt),
        .tune_code(tune_code), .unit_sel(unit_sel),
        .log_valid(log_valid), .log_ready(log_ready),
        .log_gain(log_gain), .log_temp(log_temp), .log_volt(log_volt),
        .fatal(fatal)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Reference model state: phase 0 idle, 1 settling, 2 recheck, 3 logging.
    int m_ph = 0, m_cnt = 0, m_tune = 0, m_unit = 0;
    int m_fatal = 0, m_pend = 0, m_valid = 0, m_restore = 0;
    int m_lg = 0, m_lt = 0, m_lv = 0;

    always @(posedge clk) begin : ref_model
        int  n_ph, n_cnt, n_tune, n_unit, n_fatal, n_pend, n_valid;
        bit  go_now, g_ok, c_ok;
        g_ok = (int'(gain) >= 190) && (int'(gain) <= 210);
        c_ok = g_ok && (int'(temp) >= -50) && (int'(temp) <= 150)
                    && (int'(volt) >= 1175) && (int'(volt) <= 1225);
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_tune = 0; m_unit = 0; m_fatal = 0;
            m_pend = 0; m_valid = 0; m_restore = 0;
        end else begin
            n_ph = m_ph; n_cnt = m_cnt; n_tune = m_tune; n_unit = m_unit;
            n_fatal = m_fatal; n_valid = m_valid;
            go_now = (m_ph == 0) && (test_go || m_pend != 0) && (m_fatal == 0);
            n_pend = ((m_fatal == 0) && !go_now && (m_pend != 0 || test_go)) ? 1 : 0;
            m_restore = 0;
            if (m_valid != 0 && log_ready) n_valid = 0;
            case (m_ph)
                0: if (go_now) begin
                    if (c_ok) begin
                        n_valid = 1; m_lg = gain; m_lt = temp; m_lv = volt; n_ph = 3;
                    end else begin
                        m_restore = 1; n_cnt = settle; n_ph = 1;
                    end
                end
                1: if (m_cnt == 0) n_ph = 2; else n_cnt = m_cnt - 1;
                2: if (g_ok) begin
                    n_valid = 1; m_lg = gain; m_lt = temp; m_lv = volt; n_ph = 3;
                end else if (m_tune == 7 && m_unit == 3) begin
                    n_fatal = 1; n_ph = 0;
                end else begin
                    if (m_tune < 7) n_tune = m_tune + 1;
                    else begin n_tune = 0; n_unit = m_unit + 1; end
                    n_cnt = settle; n_ph = 1;
                end
                default: if (m_valid != 0 && log_ready) n_ph = 0;
            endcase
            m_ph = n_ph; m_cnt = n_cnt; m_tune = n_tune; m_unit = n_unit;
            m_fatal = n_fatal; m_pend = n_pend; m_valid = n_valid;
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R3 restore_cmd", int'(restore_cmd), m_restore);
            check("R5 tune_code", int'(tune_code), m_tune);
            check("R6 unit_sel", int'(unit_sel), 1 << m_unit);
            check("R7 fatal", int'(fatal), m_fatal);
            check("R8 log_valid", int'(log_valid), m_valid);
            if (m_valid != 0) begin
                check("R2 log_gain", int'(log_gain), m_lg);
                check("R2 log_temp", int'(log_temp), m_lt);
                check("R2 log_volt", int'(log_volt), m_lv);
            end
            if (log_valid && log_ready) rec_cnt++;
            if (restore_cmd) rst_cnt++;
        end
    end

    task automatic pulse_go();
        @(negedge clk) test_go = 1'b1;
        @(negedge clk) test_go = 1'b0;
    endtask

    task automatic wait_log();
        for (int k = 0; k < 400 && !log_valid; k++) @(negedge clk);
    endtask

    task automatic drain(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
        $finish;
    end

    initial begin : stim
        int r0, s0, t0, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 tune_code", int'(tune_code), 0);
        check("R1 unit_sel", int'(unit_sel), 1);
        check("R1 restore_cmd", int'(restore_cmd), 0);
        check("R1 log_valid", int'(log_valid), 0);
        check("R1 fatal", int'(fatal), 0);
        cmp_on = 1'b1;

        // R2: healthy pass logs once
        #1; r0 = rec_cnt; s0 = rst_cnt;
        gain = 12'sd200; temp = 10'sd50; volt = 13'sd1200;
        pulse_go(); wait_log();
        check("R2 log gain", int'(log_gain), 200);
        check("R2 log volt", int'(log_volt), 1200);
        drain(4);
        check("R2 one record", rec_cnt - r0, 1);
        check("R2 no restore", rst_cnt - s0, 0);
        check("R2 tune unchanged", int'(tune_code), 0);

        // R10: inclusive limits accepted
        s0 = rst_cnt; r0 = rec_cnt;
        gain = 12'sd190; temp = 10'sd150; volt = 13'sd1175;
        pulse_go(); wait_log(); drain(3);
        check("R10 edge values logged", rec_cnt - r0, 1);
        check("R10 edge values no restore", rst_cnt - s0, 0);

        // R3/R4: gain 211 out, recovers during settle
        gain = 12'sd211; temp = 10'sd50; volt = 13'sd1200;
        pulse_go();
        for (int k = 0; k < 20 && !restore_cmd; k++) @(negedge clk);
        check("R10 gain 211 restores", int'(restore_cmd), 1);
        check("R3 temp setpoint", int'(temp_setpt), 50);
        check("R3 volt setpoint", int'(volt_setpt), 1200);
        gain = 12'sd200;
        n = 0;
        do begin @(negedge clk); n++; end while (!log_valid && n < 50);
        check("R3 recheck delay", n, int'(settle) + 2);
        check("R4 logged recheck gain", int'(log_gain), 200);
        check("R4 no tuning", int'(tune_code), 0);
        drain(3);

        // R9 and R10: conditions out of range with healthy gain
        s0 = rst_cnt;
        temp = 10'sd151;
        pulse_go(); temp = 10'sd50; wait_log(); drain(3);
        check("R9 temp out restores", rst_cnt - s0, 1);
        s0 = rst_cnt;
        volt = 13'sd1226;
        pulse_go(); volt = 13'sd1200; wait_log(); drain(3);
        check("R10 volt 1226 restores", rst_cnt - s0, 1);
        check("R9 tune unchanged", int'(tune_code), 0);

        // R5: partial escalation, released at code 3
        gain = 12'sd250;
        pulse_go();
        for (int k = 0; k < 200 && tune_code != 3'd3; k++) @(negedge clk);
        gain = 12'sd200;
        wait_log(); drain(3);
        check("R5 tune stopped at 3", int'(tune_code), 3);
        check("R5 same unit", int'(unit_sel), 1);

        // R8: stalled record, request during stall is remembered
        log_ready = 1'b0; r0 = rec_cnt; s0 = rst_cnt;
        pulse_go(); wait_log();
        t0 = int'(log_gain);
        gain = 12'sd300;
        test_go = 1'b1; @(negedge clk); test_go = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 valid held", int'(log_valid), 1);
        check("R8 data held", int'(log_gain), t0);
        check("R8 no new pass", rst_cnt - s0, 0);
        gain = 12'sd205;
        log_ready = 1'b1;
        drain(4);
        check("R8 pending pass logged", rec_cnt - r0, 2);

        // R6/R7: walk the whole ladder into fatal
        gain = 12'sd250; t0 = int'(unit_sel);
        pulse_go();
        for (int k = 0; k < 2000 && !fatal; k++) @(negedge clk);
        check("R7 fatal raised", int'(fatal), 1);
        check("R6 last unit", int'(unit_sel), 8);
        check("R7 last code", int'(tune_code), 7);
        #1; r0 = rec_cnt; s0 = rst_cnt;
        repeat (3) pulse_go();
        drain(10);
        check("R7 ignored restore", rst_cnt - s0, 0);
        check("R7 ignored log", rec_cnt - r0, 0);
        check("R7 still fatal", int'(fatal), 1);
        check("R7 unit held", int'(unit_sel), 8);

        report();
        $finish;
    end
endmodule